// File: doc/BRIEF.md
# Cross-Linked Serial Register Pair

Two identical serial-port register sets, one for each of two processors, whose transmitters are tied straight to the opposite receivers. No bits are shifted and no baud timing is kept: when a side has a byte waiting and the link is enabled at both ends, the byte moves into the opposite receive register on the same clock edge that carries the triggering register write.

Each side has its own single-cycle register port (write strobe, address, write data and a combinational read-back). A status write attempts a send, and so does a control write that turns transmit on. A successful send marks the sender's transmit register empty and the receiver's receive register full. Status flags can only be cleared by software, never set. Interrupt requests leave as one-cycle pulses that carry a priority level and a vector taken from the registers of the side that raises them.

Top module: `sci_link_pair`

## Requirements
- R1: Register addresses on each side are 0 control, 1 status, 2 transmit data, 3 receive data, 4 baud, 5 priority, 6 transmit vector, 7 receive vector; rdata_o shows the addressed register combinationally.
- R2: After reset the baud and transmit data registers read 0xFF, status reads 0x84, all other registers read 0x00, and no interrupt output is high.
- R3: A status write stores (old AND (data OR 0x06)) OR (data AND 0x01), where old is the value before the write. Status bit 7 is transmit-empty and bit 6 is receive-full. A write can therefore clear bits 7 and 6 but never set them, bits 2:1 keep their value, and bit 0 takes the written value.
- R4: A send attempt succeeds only when the sender's control bit 5 (transmit enable) is set and its status bit 7 is clear after the triggering write, and the receiver's control bit 4 (receive enable) is set before that edge. On success the sender's transmit byte lands in the receiver's receive register, the sender's bit 7 is set and the receiver's bit 6 is set, all at the edge of the triggering write.
- R5: A send attempt is made on every status write, and on a control write only when bit 5 goes from 0 to 1. No other write makes an attempt; this includes a control write that leaves bit 5 set.
- R6: On a successful send with the sender's control bit 7 (transmit interrupt enable) set after the write, the sender's tx_irq_o pulses for exactly the cycle after the edge. tx_lvl_o carries the sender's priority bits 7:4 and tx_vec_o carries bits 6:0 of the sender's transmit vector register. The level and vector outputs are 0 whenever the pulse is low.
- R7: On a successful send into a receiver whose control bit 6 (receive interrupt enable) is set, that receiver's rx_irq_o pulses for exactly the cycle after the edge. rx_lvl_o carries the receiver's priority bits 7:4 and rx_vec_o carries bits 6:0 of the receiver's receive vector register; both outputs are 0 whenever the pulse is low.
- R8: Writes to the transmit data, receive data, baud, priority and vector registers store the full byte and have no other effect: no send, no interrupt, and no change on the other side.
- R9: When a byte arrives in the same cycle that the receiving side writes its own receive data or status register, the arriving byte and the receive-full flag take precedence over that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 2 | Per-side write strobe |
| addr_i | input | 2x3 | Per-side register address |
| wdata_i | input | 2x8 | Per-side write data |
| rdata_o | output | 2x8 | Per-side read data for addr_i |
| tx_irq_o | output | 2 | Transmit interrupt pulse per side |
| tx_lvl_o | output | 2x4 | Transmit interrupt level |
| tx_vec_o | output | 2x7 | Transmit interrupt vector |
| rx_irq_o | output | 2 | Receive interrupt pulse per side |
| rx_lvl_o | output | 2x4 | Receive interrupt level |
| rx_vec_o | output | 2x7 | Receive interrupt vector |

## Verification
The status-write rule is swept over all 256 write values against every reachable old value of the flag bits 7, 6 and 0. This separates the clear-only flags from the held bits and the directly written bit. The send is swept in both directions over all 32 combinations of sender enable, receiver enable, empty-flag state and both interrupt enables, each time with its own byte, level and vector. This separates gating by either side and shows which side's registers feed each interrupt. Further sequences check that only a rising transmit enable starts a send, that the data and configuration writes have no side effect, and that an arriving byte wins over a write made to the receiving side in the same cycle.

// File: rtl/sci_pair_pkg.sv
package sci_pair_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int LVL_W  = 4;
  localparam int VEC_W  = 7;
  localparam int N_SIDE = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_TXD  = 3'd2,
    REG_RXD  = 3'd3,
    REG_BAUD = 3'd4,
    REG_PRIO = 3'd5,
    REG_TXV  = 3'd6,
    REG_RXV  = 3'd7
  } reg_sel_e;

  // control bits
  localparam int C_TIE = 7;
  localparam int C_RIE = 6;
  localparam int C_TE  = 5;
  localparam int C_RE  = 4;
  // status bits
  localparam int S_TDRE = 7;
  localparam int S_RDRF = 6;

  localparam logic [DATA_W-1:0] STAT_HOLD   = 8'h06;
  localparam logic [DATA_W-1:0] STAT_DIRECT = 8'h01;

  localparam logic [DATA_W-1:0] RST_BAUD = 8'hFF;
  localparam logic [DATA_W-1:0] RST_TXD  = 8'hFF;
  localparam logic [DATA_W-1:0] RST_STAT = 8'h84;

  typedef struct packed {
    logic             vld;
    logic [LVL_W-1:0] lvl;
    logic [VEC_W-1:0] vec;
  } irq_req_t;
endpackage

// File: rtl/sci_irq_pulse.sv
module sci_irq_pulse
  import sci_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  irq_req_t         req_i,
  output logic             vld_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [VEC_W-1:0] vec_o
);
  irq_req_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (req_i.vld) begin
      q <= req_i;
    end else begin
      q <= '0;
    end
  end

  assign vld_o = q.vld;
  assign lvl_o = q.lvl;
  assign vec_o = q.vec;
endmodule

// File: rtl/sci_side_regs.sv
module sci_side_regs
  import sci_pair_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              peer_re_i,
  input  logic              rx_load_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              fire_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              re_o,
  output irq_req_t          tx_req_o,
  output irq_req_t          rx_req_o
);
  logic [DATA_W-1:0] ctrl_q, stat_q, txd_q, rxd_q, baud_q, prio_q, txv_q, rxv_q;
  logic [DATA_W-1:0] ctrl_post, stat_wr_val, stat_post, stat_d, rxd_d;
  logic              wr_ctrl, wr_stat, wr_rxd, te_rise, attempt;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_ctrl = wr_i && (sel == REG_CTRL);
  assign wr_stat = wr_i && (sel == REG_STAT);
  assign wr_rxd  = wr_i && (sel == REG_RXD);

  // control and status values as seen after this cycle's write
  assign ctrl_post   = wr_ctrl ? wdata_i : ctrl_q;
  assign stat_wr_val = (stat_q & (wdata_i | STAT_HOLD)) | (wdata_i & STAT_DIRECT);
  assign stat_post   = wr_stat ? stat_wr_val : stat_q;

  assign te_rise = wr_ctrl && !ctrl_q[C_TE] && wdata_i[C_TE];
  assign attempt = wr_stat || te_rise;
  assign fire_o  = attempt && ctrl_post[C_TE] && !stat_post[S_TDRE] && peer_re_i;

  assign tx_byte_o = txd_q;
  assign re_o      = ctrl_q[C_RE];

  always_comb begin
    stat_d = stat_post;
    if (fire_o)    stat_d[S_TDRE] = 1'b1;
    if (rx_load_i) stat_d[S_RDRF] = 1'b1;
  end

  // arriving byte wins over a same-cycle local write
  assign rxd_d = rx_load_i ? rx_byte_i : (wr_rxd ? wdata_i : rxd_q);

  always_comb begin
    tx_req_o     = '0;
    tx_req_o.vld = fire_o && ctrl_post[C_TIE];
    tx_req_o.lvl = prio_q[DATA_W-1 -: LVL_W];
    tx_req_o.vec = txv_q[VEC_W-1:0];
    rx_req_o     = '0;
    rx_req_o.vld = rx_load_i && ctrl_q[C_RIE];
    rx_req_o.lvl = prio_q[DATA_W-1 -: LVL_W];
    rx_req_o.vec = rxv_q[VEC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= RST_STAT;
      txd_q  <= RST_TXD;
      rxd_q  <= '0;
      baud_q <= RST_BAUD;
      prio_q <= '0;
      txv_q  <= '0;
      rxv_q  <= '0;
    end else begin
      ctrl_q <= ctrl_post;
      stat_q <= stat_d;
      rxd_q  <= rxd_d;
      if (wr_i) begin
        case (sel)
          REG_TXD:  txd_q  <= wdata_i;
          REG_BAUD: baud_q <= wdata_i;
          REG_PRIO: prio_q <= wdata_i;
          REG_TXV:  txv_q  <= wdata_i;
          REG_RXV:  rxv_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL: rdata_o = ctrl_q;
      REG_STAT: rdata_o = stat_q;
      REG_TXD:  rdata_o = txd_q;
      REG_RXD:  rdata_o = rxd_q;
      REG_BAUD: rdata_o = baud_q;
      REG_PRIO: rdata_o = prio_q;
      REG_TXV:  rdata_o = txv_q;
      default:  rdata_o = rxv_q;
    endcase
  end

  assert_tdre_after_send_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> stat_q[S_TDRE]);

  assert_rdrf_after_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load_i |=> (stat_q[S_RDRF] && rxd_q == $past(rx_byte_i)));

  assert_held_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> $stable(stat_q[2:1]));

  assert_no_flag_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !fire_o && !rx_load_i) |=> ((stat_q[7:6] & ~$past(stat_q[7:6])) == 2'b00));
endmodule

// File: rtl/sci_link_pair.sv
module sci_link_pair
  import sci_pair_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_SIDE-1:0]              wr_i,
  input  logic [N_SIDE-1:0][ADDR_W-1:0]  addr_i,
  input  logic [N_SIDE-1:0][DATA_W-1:0]  wdata_i,
  output logic [N_SIDE-1:0][DATA_W-1:0]  rdata_o,
  output logic [N_SIDE-1:0]              tx_irq_o,
  output logic [N_SIDE-1:0][LVL_W-1:0]   tx_lvl_o,
  output logic [N_SIDE-1:0][VEC_W-1:0]   tx_vec_o,
  output logic [N_SIDE-1:0]              rx_irq_o,
  output logic [N_SIDE-1:0][LVL_W-1:0]   rx_lvl_o,
  output logic [N_SIDE-1:0][VEC_W-1:0]   rx_vec_o
);
  logic [N_SIDE-1:0]             fire, re;
  logic [N_SIDE-1:0][DATA_W-1:0] tx_byte;
  irq_req_t [N_SIDE-1:0]         tx_req, rx_req;

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    localparam int P = N_SIDE - 1 - s;

    sci_side_regs u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_i[s]),
      .addr_i    (addr_i[s]),
      .wdata_i   (wdata_i[s]),
      .rdata_o   (rdata_o[s]),
      .peer_re_i (re[P]),
      .rx_load_i (fire[P]),
      .rx_byte_i (tx_byte[P]),
      .fire_o    (fire[s]),
      .tx_byte_o (tx_byte[s]),
      .re_o      (re[s]),
      .tx_req_o  (tx_req[s]),
      .rx_req_o  (rx_req[s])
    );

    sci_irq_pulse u_tx_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (tx_req[s]),
      .vld_o  (tx_irq_o[s]),
      .lvl_o  (tx_lvl_o[s]),
      .vec_o  (tx_vec_o[s])
    );

    sci_irq_pulse u_rx_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (rx_req[s]),
      .vld_o  (rx_irq_o[s]),
      .lvl_o  (rx_lvl_o[s]),
      .vec_o  (rx_vec_o[s])
    );
  end
endmodule

// File: tb/sci_link_pair_test.sv
module sci_link_pair_test;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       wr_i = '0;
  logic [1:0][2:0]  addr_i = '0;
  logic [1:0][7:0]  wdata_i = '0;
  logic [1:0][7:0]  rdata_o;
  logic [1:0]       tx_irq_o, rx_irq_o;
  logic [1:0][3:0]  tx_lvl_o, rx_lvl_o;
  logic [1:0][6:0]  tx_vec_o, rx_vec_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sci_link_pair uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .tx_irq_o(tx_irq_o), .tx_lvl_o(tx_lvl_o), .tx_vec_o(tx_vec_o),
    .rx_irq_o(rx_irq_o), .rx_lvl_o(rx_lvl_o), .rx_vec_o(rx_vec_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int stat_rule(input int old, input int d);
    return ((old & (d | 'h06)) | (d & 'h01)) & 'hFF;
  endfunction

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst_ni = 1'b0;
    wr_i = '0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int s, input int a, input int d);
    wr_i[s] = 1'b1; addr_i[s] = a[2:0]; wdata_i[s] = d[7:0];
    @(posedge clk);
    @(negedge clk);
    wr_i = '0;
  endtask

  task automatic wr2(input int a0, input int d0, input int a1, input int d1);
    wr_i = 2'b11;
    addr_i[0] = a0[2:0]; wdata_i[0] = d0[7:0];
    addr_i[1] = a1[2:0]; wdata_i[1] = d1[7:0];
    @(posedge clk);
    @(negedge clk);
    wr_i = '0;
  endtask

  task automatic rd(input int s, input int a, output int d);
    addr_i[s] = a[2:0];
    #1 d = int'(rdata_o[s]);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input int s, input int a, input int exp);
    int v;
    rd(s, a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_rst [8];
    exp_rst = '{0, 'h84, 'hFF, 0, 'hFF, 0, 0, 0};

    // R2 / R1: reset values at every address
    do_reset();
    chk("R2 irq idle", {tx_irq_o, rx_irq_o}, 0);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 8; a++)
        rd_chk("R2 R1 reset value", s, a, exp_rst[a]);

    // R8: plain data writes store and have no side effect
    wr(0, 0, 'h20); wr(1, 0, 'h10);
    wr(0, 4, 'h12); wr(0, 5, 'hA7); wr(0, 6, 'h81); wr(0, 7, 'hFE);
    wr(0, 3, 'h33);
    wr(0, 2, 'h44);
    chk("R8 no irq after data write", {tx_irq_o, rx_irq_o}, 0);
    rd_chk("R8 baud", 0, 4, 'h12);
    rd_chk("R8 prio", 0, 5, 'hA7);
    rd_chk("R8 txv", 0, 6, 'h81);
    rd_chk("R8 rxv", 0, 7, 'hFE);
    rd_chk("R8 rxd", 0, 3, 'h33);
    rd_chk("R8 txd", 0, 2, 'h44);
    rd_chk("R8 own status untouched", 0, 1, 'h84);
    rd_chk("R8 peer rxd untouched", 1, 3, 0);
    rd_chk("R8 peer status untouched", 1, 1, 'h84);

    // R3: status write rule, every data value against every reachable old value
    for (int o = 0; o < 8; o++) begin
      for (int d = 0; d < 256; d++) begin
        int t7, t6, t0, old;
        t7 = (o >> 2) & 1; t6 = (o >> 1) & 1; t0 = o & 1;
        do_reset();
        if (t6 != 0) begin
          wr(0, 0, 'h10); wr(1, 0, 'h20); wr(1, 1, 'h00); wr(0, 0, 'h00);
        end
        wr(0, 1, (t7 << 7) | (t6 << 6) | 'h3E | t0);
        old = (t7 << 7) | (t6 << 6) | 'h04 | t0;
        wr(0, 1, d);
        rd_chk("R3 status write rule", 0, 1, stat_rule(old, d));
      end
    end

    // R4 R6 R7: send gating and interrupts, both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int c = 0; c < 32; c++) begin
        int s, r, te, re, b7, tie, rie, fire, byt, ls, lr, tv, rv, sst;
        s = dir; r = 1 - dir;
        te = c & 1; re = (c >> 1) & 1; b7 = (c >> 2) & 1;
        tie = (c >> 3) & 1; rie = (c >> 4) & 1;
        fire = te & re & (1 - b7);
        byt = (c * 37 + dir * 101 + 3) & 'hFF;
        ls = (c + dir) & 15; lr = (c * 7 + 5) & 15;
        tv = ((c * 3 + 1) & 127) | 'h80; rv = ((c * 5 + 2) & 127) | 'h80;
        do_reset();
        wr(r, 0, (re << 4) | (rie << 6));
        wr(s, 2, byt);
        wr(s, 5, (ls << 4) | 5);
        wr(s, 6, tv);
        wr(r, 5, (lr << 4) | 'hA);
        wr(r, 7, rv);
        wr(s, 0, (te << 5) | (tie << 7));
        chk("R5 no send while empty flag set", {tx_irq_o, rx_irq_o}, 0);
        wr(s, 1, b7 << 7);
        chk("R6 tx pulse", tx_irq_o[s], fire & tie);
        chk("R6 tx level", tx_lvl_o[s], (fire & tie) ? ls : 0);
        chk("R6 tx vector", tx_vec_o[s], (fire & tie) ? (tv & 127) : 0);
        chk("R7 rx pulse", rx_irq_o[r], fire & rie);
        chk("R7 rx level", rx_lvl_o[r], (fire & rie) ? lr : 0);
        chk("R7 rx vector", rx_vec_o[r], (fire & rie) ? (rv & 127) : 0);
        chk("R6 R7 no pulse on wrong side", {tx_irq_o[r], rx_irq_o[s]}, 0);
        sst = fire ? 'h84 : stat_rule('h84, b7 << 7);
        rd_chk("R4 receiver rxd", r, 3, fire ? byt : 0);
        chk("R6 R7 single-cycle pulse", {tx_irq_o, rx_irq_o}, 0);
        rd_chk("R4 receiver status", r, 1, fire ? 'hC4 : 'h84);
        rd_chk("R4 sender status", s, 1, sst);
      end
    end

    // R5: only a rising transmit enable starts a send from a control write
    do_reset();
    wr(1, 0, 'h10);
    wr(0, 2, 'h3C);
    wr(0, 1, 'h00);
    rd_chk("R5 no send with transmit off", 1, 1, 'h84);
    wr(0, 0, 'hA0);
    chk("R5 rising enable sends (tx irq)", tx_irq_o[0], 1);
    rd_chk("R5 rising enable delivers byte", 1, 3, 'h3C);
    rd_chk("R5 receiver full", 1, 1, 'hC4);
    wr(0, 2, 'h99);
    rd_chk("R8 txd write does not send", 1, 1, 'hC4);
    wr(1, 1, 'h84);
    wr(1, 0, 'h00);
    wr(0, 1, 'h00);
    rd_chk("R4 no send to disabled receiver", 0, 1, 'h04);
    wr(1, 0, 'h10);
    rd_chk("R5 receiver enable makes no attempt", 1, 1, 'h84);
    wr(0, 0, 'hA0);
    chk("R5 control write with enable kept makes no attempt", tx_irq_o[0], 0);
    rd_chk("R5 no send on kept enable", 1, 1, 'h84);
    wr(0, 0, 'h80);
    wr(0, 0, 'hA0);
    rd_chk("R5 second rising edge sends", 1, 3, 'h99);

    // R9: arriving byte wins over same-cycle local writes
    do_reset();
    wr(0, 0, 'h10); wr(1, 0, 'h20); wr(1, 2, 'h5A);
    wr2(3, 'h11, 1, 'h00);
    rd_chk("R9 arriving byte beats rxd write", 0, 3, 'h5A);
    do_reset();
    wr(0, 0, 'h10); wr(1, 0, 'h20); wr(1, 2, 'h6B);
    wr2(1, 'h00, 1, 'h00);
    rd_chk("R9 full flag beats status write", 0, 1, 'h44);
    rd_chk("R9 byte delivered", 0, 3, 'h6B);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule